// File: doc/BRIEF.md
# Software-Generated Interrupt Controller

This block raises inter-processor software interrupts among up to `NCPU` processors, each with `NID` software interrupt numbers. For every pair of receiving processor and interrupt number it holds a mask that records which originating processors asked for the interrupt, along with a pending flag. The pending flags of all pairs leave the block as one registered bitmap. Prioritisation and delivery are left to logic downstream.

A processor reaches the block through one register port. Every access carries that processor's index. One region is a write-only trigger register. The trigger word selects an interrupt number, a list of receivers and a filter mode. Two further 16-byte regions give each processor direct access to its own source masks, one byte per interrupt number. One of these regions sets mask bits and the other clears them. Reads are answered one cycle later.

Top module: `sgi_ctrl`

## Requirements
- R1: Reset (synchronous, active high) clears every source mask and every pending flag, so `pend_o` is zero and window reads return zero.
- R2: A trigger write (region 0) with mode `bus_wdata[25:24]`=0 takes the receivers from the list in `bus_wdata[23:16]` and the interrupt number from `bus_wdata[3:0]`. For each receiver it ORs the writer's bit (bit `bus_cpu`) into the source mask and sets the pending flag.
- R3: Trigger mode 1 selects every online processor except the writer.
- R4: Trigger mode 2 selects only the writer.
- R5: Trigger mode 3 is reserved, and such a write changes no state.
- R6: Receivers whose index is equal to or greater than `online_cnt` are never selected, in any mode.
- R7: A write to the set region (region 1) ORs the data byte into the requester's source mask. If the resulting mask is nonzero, the pending flag is set. A zero byte changes nothing.
- R8: A write to the clear region (region 2) removes the written bits from the requester's source mask. The pending flag drops only when the mask becomes zero.
- R9: A narrow access (`bus_wide`=0) addresses interrupt number `bus_offset` and uses data bits [7:0]. A wide access covers the four numbers starting at `4*bus_offset[3:2]`, with byte lane k (bits 8k+7..8k) belonging to number base+k.
- R10: A read gives `rd_valid` and `rd_data` on the cycle after it is accepted. Reads of either window return the requester's source masks in the R9 byte layout. Reads of region 0 and region 3 return zero, and writes to region 3 have no effect.
- R11: Window accesses touch only the requester's own masks and flags.
- R12: The effect of a write appears on `pend_o` one cycle after the write is accepted. Bit `t*NID+i` of `pend_o` is the flag of receiver t, number i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| online_cnt | input | 4 | Number of online processors (0..NCPU) |
| bus_valid | input | 1 | Access request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_region | input | 2 | 0 trigger, 1 set window, 2 clear window, 3 unused |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 8-bit access |
| bus_offset | input | 4 | Byte offset inside the window |
| bus_cpu | input | 3 | Index of the requesting processor |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| pend_o | output | 128 | Pending flags, receiver-major |

## Verification
The bench puts a trigger list that names processors beyond `online_cnt` next to valid ones. A design that skipped the online filter would raise bits at those offline receivers. It sends a mode-3 trigger with a full list, which a design that treated the reserved mode as mode 0 would act on. It also runs clear writes that remove only part of a mask. A flag dropped on any clear, rather than on an empty mask, shows up at once on `pend_o`. Wide accesses at a nonzero aligned offset, with a zero lane among live ones, catch swapped lanes and a zero byte that wrongly sets a flag. Narrow writes with junk in the upper bytes catch designs that decode the wrong lane.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  typedef enum logic [1:0] {
    RGN_TRIG = 2'd0,
    RGN_SET  = 2'd1,
    RGN_CLR  = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_RSVD   = 2'd3
  } filter_e;

  localparam int TRIG_ID_LSB   = 0;
  localparam int TRIG_LIST_LSB = 16;
  localparam int TRIG_MODE_LSB = 24;
endpackage

// File: rtl/sgi_target_sel.sv
module sgi_target_sel #(
  parameter int NCPU = 8,
  localparam int CPUW = $clog2(NCPU),
  localparam int CNTW = $clog2(NCPU + 1)
) (
  input  sgi_pkg::filter_e  mode,
  input  logic [NCPU-1:0]   list,
  input  logic [CPUW-1:0]   writer,
  input  logic [CNTW-1:0]   online_cnt,
  output logic [NCPU-1:0]   tgt_mask
);
  logic [NCPU-1:0] online_mask;
  logic [NCPU-1:0] self_bit;
  logic [NCPU-1:0] raw;

  always_comb begin
    if (int'(online_cnt) >= NCPU) online_mask = '1;
    else online_mask = (NCPU'(1) << online_cnt) - NCPU'(1);
    self_bit = NCPU'(1) << writer;
    case (mode)
      sgi_pkg::FLT_LIST:   raw = list;
      sgi_pkg::FLT_OTHERS: raw = ~self_bit;
      sgi_pkg::FLT_SELF:   raw = self_bit;
      default:             raw = '0;
    endcase
    tgt_mask = raw & online_mask;
  end
endmodule

// File: rtl/sgi_lane_map.sv
module sgi_lane_map #(
  parameter int NID = 16,
  localparam int IDW = $clog2(NID)
) (
  input  logic           wide,
  input  logic [IDW-1:0] offset,
  output logic [NID-1:0] id_hit
);
  for (genvar i = 0; i < NID; i++) begin : g_id
    localparam logic [IDW-1:0] ID = IDW'(i);
    assign id_hit[i] = wide ? (ID[IDW-1:2] == offset[IDW-1:2]) : (ID == offset);
  end
endmodule

// File: rtl/sgi_slot.sv
module sgi_slot #(
  parameter int NCPU = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig_hit,
  input  logic [NCPU-1:0] writer_bit,
  input  logic            set_hit,
  input  logic            clr_hit,
  input  logic [NCPU-1:0] wbyte,
  output logic [NCPU-1:0] src_q,
  output logic            pend_q
);
  logic [NCPU-1:0] src_d;
  logic            pend_d;

  always_comb begin
    src_d  = src_q;
    pend_d = pend_q;
    if (trig_hit) begin
      src_d  = src_q | writer_bit;
      pend_d = 1'b1;
    end else if (set_hit) begin
      src_d = src_q | wbyte;
      if (src_d != '0) pend_d = 1'b1;
    end else if (clr_hit) begin
      src_d = src_q & ~wbyte;
      if (src_d == '0) pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/sgi_ctrl.sv
module sgi_ctrl #(
  parameter int NCPU = 8,
  parameter int NID  = 16,
  localparam int CPUW = $clog2(NCPU),
  localparam int IDW  = $clog2(NID),
  localparam int CNTW = $clog2(NCPU + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNTW-1:0]     online_cnt,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [1:0]          bus_region,
  input  logic                bus_wide,
  input  logic [IDW-1:0]      bus_offset,
  input  logic [CPUW-1:0]     bus_cpu,
  input  logic [31:0]         bus_wdata,
  output logic                rd_valid,
  output logic [31:0]         rd_data,
  output logic [NCPU*NID-1:0] pend_o
);
  import sgi_pkg::*;

  localparam int SLOTS = NCPU * NID;

  region_e          rgn;
  filter_e          mode;
  logic             wr_trig, wr_set, wr_clr;
  logic [IDW-1:0]   trig_id;
  logic [NCPU-1:0]  tgt_mask;
  logic [NCPU-1:0]  writer_bit;
  logic [NID-1:0]   id_hit;
  logic [SLOTS*NCPU-1:0] src_flat;
  logic [31:0]      rd_next;
  logic [IDW-1:0]   base_id;

  assign rgn        = region_e'(bus_region);
  assign mode       = filter_e'(bus_wdata[TRIG_MODE_LSB +: 2]);
  assign trig_id    = bus_wdata[TRIG_ID_LSB +: IDW];
  assign wr_trig    = bus_valid && bus_write && (rgn == RGN_TRIG);
  assign wr_set     = bus_valid && bus_write && (rgn == RGN_SET);
  assign wr_clr     = bus_valid && bus_write && (rgn == RGN_CLR);
  assign writer_bit = NCPU'(1) << bus_cpu;

  sgi_target_sel #(.NCPU(NCPU)) u_tsel (
    .mode       (mode),
    .list       (bus_wdata[TRIG_LIST_LSB +: NCPU]),
    .writer     (bus_cpu),
    .online_cnt (online_cnt),
    .tgt_mask   (tgt_mask)
  );

  sgi_lane_map #(.NID(NID)) u_lane (
    .wide   (bus_wide),
    .offset (bus_offset),
    .id_hit (id_hit)
  );

  for (genvar t = 0; t < NCPU; t++) begin : g_tgt
    for (genvar i = 0; i < NID; i++) begin : g_id
      localparam int LANE = i % 4;
      logic [NCPU-1:0] wbyte;
      logic            own;
      assign wbyte = bus_wide ? bus_wdata[8*LANE +: NCPU] : bus_wdata[0 +: NCPU];
      assign own   = (bus_cpu == CPUW'(t)) && id_hit[i];

      sgi_slot #(.NCPU(NCPU)) u_slot (
        .clk        (clk),
        .rst        (rst),
        .trig_hit   (wr_trig && tgt_mask[t] && (trig_id == IDW'(i))),
        .writer_bit (writer_bit),
        .set_hit    (wr_set && own),
        .clr_hit    (wr_clr && own),
        .wbyte      (wbyte),
        .src_q      (src_flat[(t*NID+i)*NCPU +: NCPU]),
        .pend_q     (pend_o[t*NID+i])
      );
    end
  end

  assign base_id = {bus_offset[IDW-1:2], 2'b00};

  always_comb begin
    rd_next = '0;
    if (rgn == RGN_SET || rgn == RGN_CLR) begin
      if (bus_wide) begin
        for (int k = 0; k < 4; k++)
          rd_next[8*k +: NCPU] =
            src_flat[(int'(bus_cpu)*NID + int'(base_id) + k)*NCPU +: NCPU];
      end else begin
        rd_next[0 +: NCPU] =
          src_flat[(int'(bus_cpu)*NID + int'(bus_offset))*NCPU +: NCPU];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_valid && !bus_write;
      rd_data  <= (bus_valid && !bus_write) ? rd_next : '0;
    end
  end
endmodule

// File: rtl/sgi_ctrl_chk.sv
module sgi_ctrl_chk #(
  parameter int NCPU = 8,
  parameter int NID  = 16,
  localparam int CPUW = $clog2(NCPU),
  localparam int IDW  = $clog2(NID),
  localparam int CNTW = $clog2(NCPU + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic [CNTW-1:0]     online_cnt,
  input logic                bus_valid,
  input logic                bus_write,
  input logic [1:0]          bus_region,
  input logic                bus_wide,
  input logic [IDW-1:0]      bus_offset,
  input logic [CPUW-1:0]     bus_cpu,
  input logic [31:0]         bus_wdata,
  input logic                rd_valid,
  input logic [31:0]         rd_data,
  input logic [NCPU*NID-1:0] pend_o
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pend_o == '0));

  p_self_target_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_region == 2'd0 && bus_wdata[25:24] == 2'd2
     && int'(bus_cpu) < int'(online_cnt))
    |=> pend_o[int'($past(bus_cpu))*NID + int'($past(bus_wdata[IDW-1:0]))]);

  p_reserved_mode_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_region == 2'd0 && bus_wdata[25:24] == 2'd3)
    |=> $stable(pend_o));

  p_set_raises_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_region == 2'd1 && !bus_wide && bus_wdata[NCPU-1:0] != '0)
    |=> pend_o[int'($past(bus_cpu))*NID + int'($past(bus_offset))]);

  p_clear_all_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_region == 2'd2 && !bus_wide && bus_wdata[NCPU-1:0] == '1)
    |=> !pend_o[int'($past(bus_cpu))*NID + int'($past(bus_offset))]);

  p_read_latency_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> rd_valid);

  p_trig_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && (bus_region == 2'd0 || bus_region == 2'd3)) |=> (rd_data == '0));

  p_idle_stable_r12: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_write) |=> $stable(pend_o));
endmodule

bind sgi_ctrl sgi_ctrl_chk #(.NCPU(NCPU), .NID(NID)) chk_i (.*);

// File: tb/sgi_ctrl_tb_top.sv
`timescale 1ns/1ps
module sgi_ctrl_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   online_cnt = 4'd4;
  logic         bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
  logic [1:0]   bus_region = 2'd0;
  logic [3:0]   bus_offset = 4'd0;
  logic [2:0]   bus_cpu = 3'd0;
  logic [31:0]  bus_wdata = '0;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic [127:0] pend_o;

  int errors = 0, checks = 0;
  logic [7:0] m_src [8][16];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  sgi_ctrl dut_i (.*);

  // monitor: pops the scoreboard on every read response
  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected read response got=%h exp=none", rd_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string tg = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s read got=%h exp=%h", tg, rd_data, e);
        end
      end
    end
  end

  function automatic logic [7:0] online_mask();
    return (online_cnt >= 8) ? 8'hFF : 8'((9'd1 << online_cnt) - 9'd1);
  endfunction

  task automatic bus_op(input logic wr, input logic [1:0] rg, input logic wd,
                        input logic [3:0] off, input logic [2:0] cpu, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_region = rg; bus_wide = wd;
    bus_offset = off; bus_cpu = cpu; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic trig(input logic [2:0] cpu, input logic [1:0] mode, input logic [7:0] list, input logic [3:0] id);
    logic [7:0] self, tg;
    self = 8'd1 << cpu;
    case (mode)
      2'd0: tg = list;
      2'd1: tg = ~self;
      2'd2: tg = self;
      default: tg = 8'd0;
    endcase
    tg &= online_mask();
    bus_op(1'b1, 2'd0, 1'b0, 4'd0, cpu, {6'd0, mode, list, 12'd0, id});
    for (int t = 0; t < 8; t++) if (tg[t]) m_src[t][id] |= self;
  endtask

  task automatic win_wr(input logic clr, input logic wd, input logic [3:0] off,
                        input logic [2:0] cpu, input logic [31:0] d);
    bus_op(1'b1, clr ? 2'd2 : 2'd1, wd, off, cpu, d);
    for (int k = 0; k < 4; k++) begin
      automatic int id = wd ? ({off[3:2], 2'b00} + k) : off;
      automatic logic [7:0] b = wd ? d[8*k +: 8] : d[7:0];
      if (!wd && k > 0) break;
      if (clr) m_src[cpu][id] &= ~b; else m_src[cpu][id] |= b;
    end
  endtask

  task automatic rd(input logic [1:0] rg, input logic wd, input logic [3:0] off,
                    input logic [2:0] cpu, input string tg);
    logic [31:0] e;
    e = '0;
    if (rg == 2'd1 || rg == 2'd2) begin
      if (wd) for (int k = 0; k < 4; k++) e[8*k +: 8] = m_src[cpu][{off[3:2], 2'b00} + k];
      else e[7:0] = m_src[cpu][off];
    end
    exp_q.push_back(e); tag_q.push_back(tg);
    bus_op(1'b0, rg, wd, off, cpu, 32'hDEAD_BEEF);
  endtask

  task automatic chk_pend(input string tg);
    logic [127:0] e;
    for (int t = 0; t < 8; t++)
      for (int i = 0; i < 16; i++) e[t*16+i] = (m_src[t][i] != 8'd0);
    checks++;
    if (pend_o !== e) begin
      errors++;
      $display("FAIL %s pend got=%h exp=%h", tg, pend_o, e);
    end
  endtask

  task automatic clear_model();
    for (int t = 0; t < 8; t++) for (int i = 0; i < 16; i++) m_src[t][i] = 8'd0;
  endtask

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_pend("R1 after reset");
    rd(2'd1, 1'b1, 4'd0, 3'd0, "R1 window zero");

    trig(3'd1, 2'd0, 8'b1010_0101, 4'd3);
    chk_pend("R2 R6 list with offline targets R12");
    rd(2'd1, 1'b1, 4'd0, 3'd0, "R2 R9 wide lane 3");
    rd(2'd2, 1'b0, 4'd3, 3'd2, "R9 narrow read clear window R10");
    rd(2'd1, 1'b0, 4'd3, 3'd1, "R2 non-target stays zero");

    trig(3'd2, 2'd1, 8'h00, 4'd7);
    chk_pend("R3 all but writer");
    trig(3'd3, 2'd2, 8'hFF, 4'd15);
    chk_pend("R4 self only");
    trig(3'd0, 2'd3, 8'hFF, 4'd1);
    chk_pend("R5 reserved mode ignored");

    win_wr(1'b0, 1'b1, 4'd9, 3'd1, 32'h0040_0081);
    chk_pend("R7 R9 wide set with zero lanes R11");
    rd(2'd1, 1'b1, 4'd8, 3'd1, "R7 R9 wide readback");
    win_wr(1'b0, 1'b0, 4'd12, 3'd1, 32'h0000_AB00);
    chk_pend("R7 R9 narrow zero byte no effect");
    rd(2'd1, 1'b0, 4'd12, 3'd1, "R9 narrow upper data ignored");

    win_wr(1'b1, 1'b0, 4'd7, 3'd0, 32'h0000_0004);
    chk_pend("R8 last source cleared drops flag");
    win_wr(1'b0, 1'b0, 4'd3, 3'd0, 32'h0000_0008);
    win_wr(1'b1, 1'b0, 4'd3, 3'd0, 32'h0000_0002);
    chk_pend("R8 partial clear keeps flag");
    rd(2'd2, 1'b0, 4'd3, 3'd0, "R8 remaining source");
    win_wr(1'b1, 1'b1, 4'd8, 3'd1, 32'h0000_0081);
    chk_pend("R8 R9 wide clear lane 0 only");

    win_wr(1'b0, 1'b0, 4'd5, 3'd6, 32'h0000_0011);
    chk_pend("R11 requester-private set");
    rd(2'd1, 1'b0, 4'd5, 3'd0, "R11 other cpu unaffected");

    rd(2'd0, 1'b1, 4'd0, 3'd0, "R10 trigger reads zero");
    bus_op(1'b1, 2'd3, 1'b1, 4'd0, 3'd2, 32'hFFFF_FFFF);
    chk_pend("R10 region 3 write no effect");
    rd(2'd3, 1'b1, 4'd0, 3'd2, "R10 region 3 reads zero");

    online_cnt = 4'd8;
    trig(3'd7, 2'd1, 8'h00, 4'd0);
    chk_pend("R3 R6 eight online");
    rd(2'd1, 1'b1, 4'd0, 3'd6, "R3 receiver six sees writer seven");

    online_cnt = 4'd2;
    trig(3'd0, 2'd0, 8'hFF, 4'd2);
    chk_pend("R6 two online");

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    clear_model();
    @(negedge clk);
    chk_pend("R1 reset mid-run");
    rd(2'd1, 1'b1, 4'd4, 3'd6, "R1 masks cleared");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL R10 missing read responses got=%0d exp=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule